// File: doc/BRIEF.md
# Partial-Sum Threshold Comparator with Host Register Port

This block keeps four 19-bit threshold values and one 24-bit correction value. A narrow host bus writes and reads them one 6-bit slice at a time. On every clock it compares the incoming 19-bit partial sum with each threshold and drives, one cycle later, a per-threshold flag that is high while the sum is below that threshold. The correction value is driven out continuously for a downstream correction adder.

The host reaches the block through a card address, a function address, a strobe and a direction bit. The card address must equal the configured card ID. The function address selects a register slice. The register slices are not laid out in bit order, and each register window is mirrored a second time directly above itself. The host can also read back the six captured 16-bit input operands, which are packed back to back in 6-bit slices. For each threshold, one slice reports live comparison status instead of data.

Top module: `thr_host_top`

## Requirements
- R1: After reset all thresholds and the correction value are 0, `sumBelow` is 0 and threshold reads return 0.
- R2: `sumBelow[n]` is 1 exactly when the partial sum sampled at the previous rising edge was below threshold n, compared unsigned. The flag is due one clock after the sum is applied.
- R3: Threshold n (n = 0..3) occupies function addresses 16+8n .. 16+8n+3. Offset 0 holds bits 6..11, offset 1 holds bit 18 (write data bit 0), offset 2 holds bits 12..17 and offset 3 holds bits 0..5. Each slice reads back right-aligned.
- R4: The correction value sits at addresses 48..51. Offset 0 holds bits 6..11, offset 1 holds bits 18..23, offset 2 holds bits 12..17 and offset 3 holds bits 0..5. It is presented on `corrValue` from the clock after the write.
- R5: Inside each register window, offsets 4..7 act exactly like offsets 0..3 for both reads and writes.
- R6: Reading offset 1 of a threshold returns a status byte. Bit 5 = sum below threshold, bit 4 = sum above threshold, bit 3 = sum differs from threshold, bit 0 = threshold bit 18, and all other bits are 0. The status is live for the current sum.
- R7: Addresses 0..15 are read-only. Address a returns bits 6a..6a+5 of the 96-bit concatenation of the operands, with operand 1 in bits 0..15 and operand k in bits 16(k-1)..16k-1.
- R8: Write data bits 7..6 are ignored. Read data bits 7..6 are always 0.
- R9: A write takes effect only on the first clock cycle in which the strobe is high after being low, and only when the card address matches and the direction is write. A strobe held high writes once, and strobes in the read direction write nothing.
- R10: Writes to addresses 0..15 or to addresses of 56 and above change nothing, and reads of addresses of 56 and above return 0.
- R11: Read data is 0 whenever the card address does not match or the direction is write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardId | input | 6 | Configured card ID |
| hostCardAddr | input | 6 | Card address from the host |
| hostFuncAddr | input | 8 | Function (register) address |
| hostStrobe | input | 1 | Access strobe; its rising edge commits a write |
| hostDirWrite | input | 1 | 1 = write, 0 = read |
| hostWrData | input | 8 | Write data; only bits 5..0 are used |
| hostRdData | output | 8 | Read data, zero when not selected for a read |
| partialSum | input | 19 | Unsigned partial sum to compare |
| opndFlat | input | 96 | Six captured 16-bit operands, operand 1 in the low bits |
| sumBelow | output | 4 | Per-threshold flag: sum below threshold, registered |
| corrValue | output | 24 | Current correction value |

## Verification
Three kinds of result have different timing. Read data is combinational and appears in the same cycle as the address, card and direction inputs. A register write shows on `corrValue` and on read-back one clock after the rising edge that saw the new strobe. `sumBelow` reflects the partial sum captured at the previous edge, using the threshold values from before any write at that same edge. The bench changes inputs 1 ns after each rising edge. Its reference model updates at the rising edge in the same order: compare first, then write. All outputs are compared at the following falling edge, so every expectation is sampled exactly where the design's registers have settled.

// File: rtl/thr_pkg.sv
package thr_pkg;

  // Host register slice width and bus width
  localparam int REG_W = 6;
  localparam int BUS_W = 8;
  // Slices per register window (address offsets 0..3, mirrored at 4..7)
  localparam int SLOTS = 4;
  // Offset within a threshold window that reads back live status
  localparam logic [1:0] STATUS_SLOT = 2'd1;
  // Status byte bit positions (0-based)
  localparam int ST_LT  = 5;
  localparam int ST_GT  = 4;
  localparam int ST_NE  = 3;
  localparam int ST_TOP = 0;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_OPND,
    RD_REG
  } rdKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic [2:0] regIdx;
    logic [1:0] slot;
    rdKind_e    rdKind;
    logic [3:0] opndChunk;
  } hostCtl_t;

  // Address offset -> 6-bit chunk index inside a register (non-monotonic order)
  function automatic logic [1:0] slotToChunk(input logic [1:0] slot);
    case (slot)
      2'd0:    return 2'd1;
      2'd1:    return 2'd3;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/thr_host_ctrl.sv
module thr_host_ctrl
  import thr_pkg::*;
#(
  parameter int CID_W       = 6,
  parameter int FA_W        = 8,
  parameter int NUM_THR     = 4,
  parameter int OPND_CHUNKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CID_W-1:0] cardId,
  input  logic [CID_W-1:0] cardAddr,
  input  logic [FA_W-1:0]  funcAddr,
  input  logic             strobe,
  input  logic             dirWrite,
  output hostCtl_t         ctl
);

  localparam int GRP_LSB   = 3;              // eight addresses per window
  localparam int GRP_W     = FA_W - GRP_LSB;
  localparam int FIRST_GRP = 2;              // first register window at 16
  localparam int NUM_REGS  = NUM_THR + 1;    // thresholds plus correction

  logic             strobePrev;
  logic             strobeEdge;
  logic             selected;
  logic [GRP_W-1:0] grp;
  logic             inRegWindow;
  logic             inOpndWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobe;
  end

  assign strobeEdge   = strobe & ~strobePrev;
  assign selected     = (cardAddr == cardId);
  assign grp          = funcAddr[FA_W-1:GRP_LSB];
  assign inOpndWindow = (funcAddr < FA_W'(OPND_CHUNKS));
  assign inRegWindow  = (grp >= GRP_W'(FIRST_GRP)) &&
                        (grp <  GRP_W'(FIRST_GRP + NUM_REGS));

  always_comb begin
    ctl           = '0;
    ctl.regIdx    = 3'(grp - GRP_W'(FIRST_GRP));
    ctl.slot      = funcAddr[1:0];
    ctl.opndChunk = funcAddr[3:0];
    ctl.wrEn      = selected & dirWrite & strobeEdge & inRegWindow;
    ctl.rdKind    = RD_NONE;
    if (selected && !dirWrite) begin
      if (inOpndWindow)     ctl.rdKind = RD_OPND;
      else if (inRegWindow) ctl.rdKind = RD_REG;
    end
  end

endmodule

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int NUM_THR   = 4,
  parameter int SUM_W     = 19,
  parameter int CORR_W    = 24,
  parameter int OPND_BITS = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  hostCtl_t           ctl,
  input  logic [REG_W-1:0]   wrData,
  input  logic [SUM_W-1:0]   partialSum,
  input  logic [OPND_BITS-1:0] opndFlat,
  output logic [NUM_THR-1:0] sumBelow,
  output logic [CORR_W-1:0]  corrValue,
  output logic [BUS_W-1:0]   rdData
);

  localparam int PAD_W       = SLOTS * REG_W;
  localparam int NUM_REGS    = NUM_THR + 1;
  localparam int THR_IW      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;
  localparam int OPND_CHUNKS = (OPND_BITS + REG_W - 1) / REG_W;
  localparam int OPND_PAD    = OPND_CHUNKS * REG_W;
  localparam logic [PAD_W-1:0] THR_MASK  = {PAD_W{1'b1}} >> (PAD_W - SUM_W);
  localparam logic [PAD_W-1:0] CORR_MASK = {PAD_W{1'b1}} >> (PAD_W - CORR_W);

  logic [PAD_W-1:0]    regFile [NUM_REGS];
  logic [NUM_THR-1:0]  ltVec;
  logic [NUM_THR-1:0]  gtVec;
  logic [NUM_THR-1:0]  neVec;
  logic [NUM_THR-1:0]  sumBelowQ;
  logic [1:0]          wrChunk;
  logic [PAD_W-1:0]    entryMask;
  logic [REG_W-1:0]    wrField;
  logic [1:0]          rdChunk;
  logic [PAD_W-1:0]    rdWord;
  logic                isThr;
  logic [THR_IW-1:0]   thrSel;
  logic [OPND_PAD-1:0] opndPad;

  // ---------------- write path ----------------
  assign wrChunk   = slotToChunk(ctl.slot);
  assign isThr     = (ctl.regIdx < 3'(NUM_THR));
  assign entryMask = isThr ? THR_MASK : CORR_MASK;
  assign wrField   = wrData & entryMask[wrChunk*REG_W +: REG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (ctl.wrEn) begin
      regFile[ctl.regIdx][wrChunk*REG_W +: REG_W] <= wrField;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : gWrGuard
    AST_REG_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regFile[r]) |-> ($past(ctl.wrEn) && $past(ctl.regIdx) == 3'(r)))
      else $error("register changed without a write strobe"); // R9
  end

  // ---------------- comparators ----------------
  for (genvar t = 0; t < NUM_THR; t++) begin : gThr
    logic [SUM_W-1:0] thrVal;
    assign thrVal   = regFile[t][SUM_W-1:0];
    assign ltVec[t] = (partialSum < thrVal);
    assign gtVec[t] = (partialSum > thrVal);
    assign neVec[t] = (partialSum != thrVal);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sumBelowQ[t] <= 1'b0;
      else       sumBelowQ[t] <= ltVec[t];
    end

    AST_ZERO_THR_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
      ($past(thrVal) == '0) |-> !sumBelowQ[t])
      else $error("flag set against a zero threshold"); // R2
    AST_STATUS_CONSISTENT: assert property (@(posedge clk) disable iff (!rstN)
      ((ltVec[t] || gtVec[t]) == neVec[t]) && !(ltVec[t] && gtVec[t]))
      else $error("status bits disagree"); // R6
    AST_THR_PAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      regFile[t][PAD_W-1:SUM_W] == '0)
      else $error("threshold bits above its width set"); // R3
  end

  assign sumBelow  = sumBelowQ;
  assign corrValue = regFile[NUM_THR][CORR_W-1:0];

  // ---------------- read path ----------------
  assign opndPad = OPND_PAD'(opndFlat);
  assign rdChunk = slotToChunk(ctl.slot);
  assign thrSel  = THR_IW'(ctl.regIdx);
  assign rdWord  = (ctl.regIdx < 3'(NUM_REGS)) ? regFile[ctl.regIdx] : '0;

  always_comb begin
    rdData = '0;
    unique case (ctl.rdKind)
      RD_OPND: rdData = BUS_W'(opndPad[ctl.opndChunk*REG_W +: REG_W]);
      RD_REG: begin
        if (isThr && ctl.slot == STATUS_SLOT) begin
          rdData[ST_LT]  = ltVec[thrSel];
          rdData[ST_GT]  = gtVec[thrSel];
          rdData[ST_NE]  = neVec[thrSel];
          rdData[ST_TOP] = rdWord[SUM_W-1];
        end else begin
          rdData = BUS_W'(rdWord[rdChunk*REG_W +: REG_W]);
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/thr_host_top.sv
module thr_host_top
  import thr_pkg::*;
#(
  parameter int NUM_THR  = 4,
  parameter int SUM_W    = 19,
  parameter int CORR_W   = 24,
  parameter int OPND_W   = 16,
  parameter int NUM_OPND = 6,
  parameter int CID_W    = 6,
  parameter int FA_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [CID_W-1:0]           cardId,
  input  logic [CID_W-1:0]           hostCardAddr,
  input  logic [FA_W-1:0]            hostFuncAddr,
  input  logic                       hostStrobe,
  input  logic                       hostDirWrite,
  input  logic [BUS_W-1:0]           hostWrData,
  output logic [BUS_W-1:0]           hostRdData,
  input  logic [SUM_W-1:0]           partialSum,
  input  logic [NUM_OPND*OPND_W-1:0] opndFlat,
  output logic [NUM_THR-1:0]         sumBelow,
  output logic [CORR_W-1:0]          corrValue
);

  localparam int OPND_BITS   = NUM_OPND * OPND_W;
  localparam int OPND_CHUNKS = (OPND_BITS + REG_W - 1) / REG_W;

  hostCtl_t ctl;
  logic     unusedWrHi;

  assign unusedWrHi = ^hostWrData[BUS_W-1:REG_W];

  thr_host_ctrl #(
    .CID_W(CID_W), .FA_W(FA_W), .NUM_THR(NUM_THR), .OPND_CHUNKS(OPND_CHUNKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cardId(cardId), .cardAddr(hostCardAddr),
    .funcAddr(hostFuncAddr), .strobe(hostStrobe), .dirWrite(hostDirWrite),
    .ctl(ctl)
  );

  thr_datapath #(
    .NUM_THR(NUM_THR), .SUM_W(SUM_W), .CORR_W(CORR_W), .OPND_BITS(OPND_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(hostWrData[REG_W-1:0]),
    .partialSum(partialSum), .opndFlat(opndFlat), .sumBelow(sumBelow),
    .corrValue(corrValue), .rdData(hostRdData)
  );

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !((hostCardAddr == cardId) && !hostDirWrite) |-> (hostRdData == '0))
    else $error("read data driven while not selected for a read"); // R11
  AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[BUS_W-1:REG_W] == '0)
    else $error("read data upper bits set"); // R8

endmodule

// File: tb/thr_host_top_tb.sv
`timescale 1ns/1ps
module thr_host_top_tb;

  localparam logic [5:0] CARD = 6'h2D;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cardId = CARD;
  logic [5:0]  hostCardAddr = '0;
  logic [7:0]  hostFuncAddr = '0;
  logic        hostStrobe = 1'b0;
  logic        hostDirWrite = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic [18:0] partialSum = '0;
  logic [95:0] opndFlat = '0;
  logic [3:0]  sumBelow;
  logic [23:0] corrValue;

  int total = 0;
  int bad = 0;
  bit checking = 0;

  always #2 clk = ~clk;   // 250 MHz

  thr_host_top u_dut (
    .clk(clk), .rstN(rstN), .cardId(cardId), .hostCardAddr(hostCardAddr),
    .hostFuncAddr(hostFuncAddr), .hostStrobe(hostStrobe),
    .hostDirWrite(hostDirWrite), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .partialSum(partialSum), .opndFlat(opndFlat),
    .sumBelow(sumBelow), .corrValue(corrValue)
  );

  // ---------------- behavioural reference model ----------------
  logic [18:0] thrM [4];
  logic [23:0] corrM;
  logic [3:0]  expBelow;
  logic        prevStb;

  task automatic modelWrite(input int addr, input logic [7:0] d);
    int grp; int sl; logic [5:0] v;
    if (addr < 16 || addr >= 56) return;
    grp = (addr - 16) / 8;
    sl  = addr % 4;
    v   = d[5:0];
    if (grp < 4) begin
      case (sl)
        0: thrM[grp][11:6]  = v;
        1: thrM[grp][18]    = v[0];
        2: thrM[grp][17:12] = v;
        default: thrM[grp][5:0] = v;
      endcase
    end else begin
      case (sl)
        0: corrM[11:6]  = v;
        1: corrM[23:18] = v;
        2: corrM[17:12] = v;
        default: corrM[5:0] = v;
      endcase
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) thrM[i] = '0;
      corrM = '0; expBelow = '0; prevStb = 1'b0;
    end else begin
      for (int i = 0; i < 4; i++) expBelow[i] = (partialSum < thrM[i]);
      if (hostStrobe && !prevStb && hostCardAddr == CARD && hostDirWrite)
        modelWrite(int'(hostFuncAddr), hostWrData);
      prevStb = hostStrobe;
    end
  end

  function automatic logic [7:0] expRd();
    int a; int grp; int sl; logic [7:0] r; logic [18:0] s;
    r = '0;
    a = int'(hostFuncAddr);
    if (hostCardAddr != CARD || hostDirWrite) return r;
    if (a < 16) begin
      for (int b = 0; b < 6; b++) begin
        int g; g = a * 6 + b;
        r[b] = opndFlat[(g / 16) * 16 + (g % 16)];
      end
      return r;
    end
    if (a >= 56) return r;
    grp = (a - 16) / 8; sl = a % 4;
    if (grp < 4) begin
      s = thrM[grp];
      case (sl)
        0: r[5:0] = s[11:6];
        1: begin
          r[5] = (partialSum < s); r[4] = (partialSum > s);
          r[3] = (partialSum != s); r[0] = s[18];
        end
        2: r[5:0] = s[17:12];
        default: r[5:0] = s[5:0];
      endcase
    end else begin
      case (sl)
        0: r[5:0] = corrM[11:6];
        1: r[5:0] = corrM[23:18];
        2: r[5:0] = corrM[17:12];
        default: r[5:0] = corrM[5:0];
      endcase
    end
    return r;
  endfunction

  function automatic string rdTag();
    int a; a = int'(hostFuncAddr);
    if (hostCardAddr != CARD || hostDirWrite) return "R11";
    if (a < 16) return "R7";
    if (a >= 56) return "R10";
    if (a % 8 >= 4) return "R5";
    if (a < 48 && a % 4 == 1) return "R6";
    if (a < 48) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && checking) begin
      chk("R2", 32'(sumBelow), 32'(expBelow));
      chk("R4", 32'(corrValue), 32'(corrM));
      chk(rdTag(), 32'(hostRdData), 32'(expRd()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data,
                    input logic [5:0] card = CARD);
    hostCardAddr = card; hostDirWrite = 1'b1; hostFuncAddr = addr;
    hostWrData = data; hostStrobe = 1'b1;
    tick();
    hostStrobe = 1'b0;
    tick();
  endtask

  task automatic rdSet(input logic [7:0] addr);
    hostCardAddr = CARD; hostDirWrite = 1'b0; hostFuncAddr = addr;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    checking = 1;

    // R1: reset state
    rdSet(8'd16);
    @(negedge clk);
    chk("R1", 32'(hostRdData), 32'h0);
    chk("R1", 32'(sumBelow), 32'h0);
    chk("R1", 32'(corrValue), 32'h0);
    tick();

    // R3: program threshold 0 = 266181
    wr(8'd16, 8'h3F); wr(8'd17, 8'h01); wr(8'd18, 8'h00); wr(8'd19, 8'h05);
    rdSet(8'd16);
    partialSum = 19'd266180;
    tick(); @(negedge clk);
    chk("R2", 32'(sumBelow), 32'h1);
    chk("R3", 32'(hostRdData), 32'h3F);
    partialSum = 19'd266181;
    tick(); @(negedge clk);
    chk("R2", 32'(sumBelow), 32'h0);

    // R6: status byte
    rdSet(8'd17);
    #0.5; @(negedge clk);
    chk("R6", 32'(hostRdData), 32'h01);
    partialSum = 19'd266182;
    tick(); @(negedge clk);
    chk("R6", 32'(hostRdData), 32'h19);
    partialSum = 19'd0;
    tick(); @(negedge clk);
    chk("R6", 32'(hostRdData), 32'h29);

    // R5: alias window
    wr(8'd20, 8'h00);
    rdSet(8'd16);
    @(negedge clk);
    chk("R5", 32'(hostRdData), 32'h00);
    rdSet(8'd21);
    @(negedge clk);
    chk("R5", 32'(hostRdData), 32'h29);
    tick();

    // R4: correction value
    wr(8'd48, 8'h11); wr(8'd49, 8'h2A); wr(8'd50, 8'h33); wr(8'd51, 8'h04);
    rdSet(8'd49);
    @(negedge clk);
    chk("R4", 32'(corrValue), 32'hAB3444);
    chk("R4", 32'(hostRdData), 32'h2A);
    tick();

    // R8: upper write bits ignored, upper read bits zero
    wr(8'd19, 8'hFF); wr(8'd17, 8'hFE);
    rdSet(8'd19);
    @(negedge clk);
    chk("R8", 32'(hostRdData), 32'h3F);
    rdSet(8'd17);
    @(negedge clk);
    chk("R8", 32'(hostRdData), 32'h28);
    tick();

    // R7: packed operand read-back
    opndFlat = '0;
    opndFlat[15:0]  = 16'hABCD;
    opndFlat[31:16] = 16'h1237;
    rdSet(8'd2);
    @(negedge clk);
    chk("R7", 32'(hostRdData), 32'h3A);
    rdSet(8'd0);
    @(negedge clk);
    chk("R7", 32'(hostRdData), 32'h0D);
    tick();

    // R10: read-only and unmapped addresses
    wr(8'd3, 8'h15); wr(8'd56, 8'h3F); wr(8'h90, 8'h3F); wr(8'd60, 8'h3F);
    rdSet(8'd16);
    @(negedge clk);
    chk("R10", 32'(hostRdData), 32'h00);
    rdSet(8'd60);
    @(negedge clk);
    chk("R10", 32'(hostRdData), 32'h00);
    chk("R10", 32'(corrValue), 32'hAB3444);
    tick();

    // R9: wrong card, held strobe, read-direction strobe
    wr(8'd18, 8'h2A, CARD ^ 6'h01);
    rdSet(8'd18);
    @(negedge clk);
    chk("R9", 32'(hostRdData), 32'h00);
    tick();
    hostCardAddr = CARD; hostDirWrite = 1'b1; hostFuncAddr = 8'd18;
    hostWrData = 8'h01; hostStrobe = 1'b1;
    tick();
    hostWrData = 8'h02;
    tick(); tick();
    hostStrobe = 1'b0;
    tick();
    hostDirWrite = 1'b0; hostWrData = 8'h3F; hostStrobe = 1'b1;
    tick();
    hostStrobe = 1'b0;
    tick();
    rdSet(8'd18);
    @(negedge clk);
    chk("R9", 32'(hostRdData), 32'h01);

    // R11: not selected or write direction -> zero
    hostCardAddr = CARD ^ 6'h04;
    #0.5; @(negedge clk);
    chk("R11", 32'(hostRdData), 32'h00);
    hostCardAddr = CARD; hostDirWrite = 1'b1;
    #0.5; @(negedge clk);
    chk("R11", 32'(hostRdData), 32'h00);
    tick();

    // Mixed traffic, checked every cycle against the model
    for (int c = 0; c < 3000; c++) begin
      hostFuncAddr = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 64);
      hostCardAddr = ($urandom % 5 == 0) ? 6'($urandom) : CARD;
      hostDirWrite = 1'($urandom);
      hostStrobe   = 1'($urandom);
      hostWrData   = 8'($urandom);
      if ($urandom % 2 == 1)
        partialSum = 19'(thrM[$urandom % 4] + 19'($urandom % 3) - 19'd1);
      else
        partialSum = 19'($urandom);
      if (c % 16 == 0)
        opndFlat = {$urandom, $urandom, $urandom};
      tick();
    end

    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule